// File: doc/BRIEF.md
# Pulse-width frame receiver and filter

This block sits on a single-wire bus on which every bit is a high pulse followed by a low gap. The length of the high pulse carries the value: a short pulse is a 0 and a long pulse is a 1. Another part of the system spots the start pulse and raises `go` for one cycle while the line is still high. The receiver then waits for the line to fall, and from that edge onward it times each high pulse in clock cycles. It packs the recovered bits into bytes, most significant bit first.

The first byte of a frame is a flags byte. It carries a two-bit direction field in bits 7..6 and a five-bit length field in bits 4..0. The second byte is an address, which is compared against the local node identifier. Next come a command byte and `length` data bytes. Accepted command and data bytes go to an external buffer through a write strobe. Two check bytes close the frame. A bit-serial CRC-16 is run over every bit of the frame, and the frame is good when the CRC register returns to zero. The outcome appears as a one-cycle `done` pulse with a coded result, the length field and a broadcast flag.

Top module: `pw_frame_rx`

## Requirements
- R1: After reset, `done`, `wr_en`, `err_code`, `data_cnt` and `bcast` are all 0.
- R2: A bit whose high time lasts THRESH (default 9) or more sampled clock cycles is a 1, and a shorter high time is a 0. Bits are assembled into bytes MSB first. Bit decoding starts at the falling edge of the start pulse that follows `go`.
- R3: A high time or a low gap of exactly TIMEOUT (default 24) cycles is accepted. A phase that lasts one cycle longer aborts the frame without a `done` pulse or further writes. The block is then idle and accepts the next `go`.
- R4: A flags byte whose direction field (bits 7..6) is 2'b00 causes the frame to be dropped silently: no `done` pulse and no writes.
- R5: The frame is accepted when the address byte equals `node_id` or equals 8'hFF. Broadcast address 8'hFF sets `bcast` to 1, and a match on `node_id` sets it to 0.
- R6: Any other address ends the frame with `done` and `err_code`=1, `bcast`=0 and no writes.
- R7: When the length field plus one exceeds DEPTH (default 16), the frame ends with `done` and `err_code`=2 right after the flags byte, with no writes. Length plus one equal to DEPTH is accepted.
- R8: An accepted frame writes the command byte and the `length` data bytes in arrival order, at buffer addresses 0 through `length`, one `wr_en` strobe per byte.
- R9: The CRC register starts at 0. For each received bit b, in arrival order, it is shifted right by one; if b XOR the old bit 0 is 1, it is also XORed with 16'hA001. This covers the flags, address, command, data and both check bytes. At the end of the frame, a non-zero register gives `err_code`=3 and zero gives `err_code`=0. In both cases `data_cnt` holds the length field.
- R10: `done` is high for exactly one cycle per completed frame and never in the same cycle as `wr_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| go | input | 1 | One-cycle pulse: start pulse seen, line still high |
| line | input | 1 | Bus level, synchronous to clk |
| node_id | input | 8 | Local address |
| wr_en | output | 1 | Buffer write strobe |
| wr_addr | output | $clog2(DEPTH) | Buffer write address |
| wr_data | output | 8 | Buffer write data |
| done | output | 1 | Frame finished, result valid |
| err_code | output | 2 | 0 ok, 1 not for this node, 2 too long, 3 CRC fail |
| data_cnt | output | 5 | Length field of the finished frame |
| bcast | output | 1 | Frame was addressed to 8'hFF |

## Verification
The bit decision and the timeout both act on the same cycle counter. A high pulse can therefore end in the very cycle the counter reaches its limit. The bench drives 1-bits with a high time of exactly TIMEOUT cycles, and separately a gap of exactly TIMEOUT cycles, and expects a clean frame. It then stretches one pulse and one gap by a single cycle, and expects silence followed by a normal frame. The threshold edge is covered in the same way, with 0-bits of THRESH-1 cycles and 1-bits of THRESH cycles judged by the written data and the CRC result.

// File: rtl/pw_frame_rx.sv
module pw_frame_rx #(
  parameter int THRESH  = 9,
  parameter int TIMEOUT = 24,
  parameter int DEPTH   = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     go,
  input  logic                     line,
  input  logic [7:0]               node_id,
  output logic                     wr_en,
  output logic [$clog2(DEPTH)-1:0] wr_addr,
  output logic [7:0]               wr_data,
  output logic                     done,
  output logic [1:0]               err_code,
  output logic [4:0]               data_cnt,
  output logic                     bcast
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(TIMEOUT + 1);

  typedef enum logic [1:0] {S_IDLE, S_START, S_LOW, S_HIGH} st_t;
  typedef enum logic [2:0] {P_FLAGS, P_ADDR, P_DATA, P_CRC1, P_CRC2} ph_t;

  st_t          st;
  ph_t          ph;
  logic         l1;
  logic [CW-1:0] cnt;
  logic [2:0]   bitn;
  logic [6:0]   sh;
  logic [15:0]  crc;
  logic [4:0]   len, idx;
  logic         bc;

  logic         bit_v, fb;
  logic [7:0]   byte_v;
  logic [15:0]  crc_nx;
  logic         at_limit;

  assign bit_v    = 32'(cnt) >= THRESH;
  assign byte_v   = {sh, bit_v};
  assign fb       = crc[0] ^ bit_v;
  assign crc_nx   = {1'b0, crc[15:1]} ^ (fb ? 16'hA001 : 16'h0000);
  assign at_limit = cnt == CW'(TIMEOUT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      ph <= P_FLAGS;
      l1 <= 1'b0;
      cnt <= '0;
      bitn <= '0;
      sh <= '0;
      crc <= '0;
      len <= '0;
      idx <= '0;
      bc <= 1'b0;
      wr_en <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      done <= 1'b0;
      err_code <= '0;
      data_cnt <= '0;
      bcast <= 1'b0;
    end else begin
      l1 <= line;
      wr_en <= 1'b0;
      done <= 1'b0;
      case (st)
        S_IDLE: if (go) begin
          st <= S_START;
          ph <= P_FLAGS;
          bitn <= '0;
          crc <= '0;
        end
        S_START: if (!l1) begin
          st <= S_LOW;
          cnt <= CW'(1);
        end
        S_LOW: begin
          if (l1) begin
            st <= S_HIGH;
            cnt <= CW'(1);
          end else if (at_limit) st <= S_IDLE;
          else cnt <= cnt + 1'b1;
        end
        S_HIGH: begin
          if (l1) begin
            if (at_limit) st <= S_IDLE;
            else cnt <= cnt + 1'b1;
          end else begin
            st <= S_LOW;
            cnt <= CW'(1);
            sh <= byte_v[6:0];
            crc <= crc_nx;
            bitn <= bitn + 3'd1;
            if (bitn == 3'd7) begin
              case (ph)
                P_FLAGS: begin
                  len <= byte_v[4:0];
                  if (byte_v[7:6] == 2'b00) st <= S_IDLE;
                  else if (32'(byte_v[4:0]) + 1 > DEPTH) begin
                    st <= S_IDLE;
                    done <= 1'b1;
                    err_code <= 2'd2;
                    data_cnt <= byte_v[4:0];
                    bcast <= 1'b0;
                  end else ph <= P_ADDR;
                end
                P_ADDR: begin
                  idx <= '0;
                  if (byte_v == node_id) begin
                    bc <= 1'b0;
                    ph <= P_DATA;
                  end else if (byte_v == 8'hFF) begin
                    bc <= 1'b1;
                    ph <= P_DATA;
                  end else begin
                    st <= S_IDLE;
                    done <= 1'b1;
                    err_code <= 2'd1;
                    data_cnt <= len;
                    bcast <= 1'b0;
                  end
                end
                P_DATA: begin
                  wr_en <= 1'b1;
                  wr_addr <= idx[AW-1:0];
                  wr_data <= byte_v;
                  idx <= idx + 5'd1;
                  if (idx == len) ph <= P_CRC1;
                end
                P_CRC1: ph <= P_CRC2;
                default: begin
                  st <= S_IDLE;
                  done <= 1'b1;
                  err_code <= (crc_nx != 16'h0000) ? 2'd3 : 2'd0;
                  data_cnt <= len;
                  bcast <= bc;
                end
              endcase
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pw_frame_rx_chk.sv
module pw_frame_rx_chk #(
  parameter int DEPTH = 16
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     wr_en,
  input logic [$clog2(DEPTH)-1:0] wr_addr,
  input logic                     done,
  input logic [1:0]               err_code,
  input logic [4:0]               data_cnt,
  input logic                     bcast
);
  logic wr_seen;
  logic [$clog2(DEPTH)-1:0] last_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_seen <= 1'b0;
      last_addr <= '0;
    end else begin
      if (done) wr_seen <= 1'b0;
      else if (wr_en) begin
        wr_seen <= 1'b1;
        last_addr <= wr_addr;
      end
    end
  end

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_no_wr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && wr_en));
  assert_len_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err_code == 2'd2) |-> (32'(data_cnt) + 1 > DEPTH));
  assert_len_ok_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (err_code == 2'd0 || err_code == 2'd3)) |-> (32'(data_cnt) + 1 <= DEPTH));
  assert_addr_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err_code == 2'd1) |-> (!bcast && !wr_seen));
  assert_last_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && wr_seen && err_code != 2'd2) |-> (32'(last_addr) == 32'(data_cnt)));
endmodule

bind pw_frame_rx pw_frame_rx_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .done(done), .err_code(err_code), .data_cnt(data_cnt), .bcast(bcast)
);

// File: tb/sim_pw_frame_rx.sv
module sim_pw_frame_rx;
  localparam int THRESH = 9, TIMEOUT = 24, DEPTH = 16;

  logic clk = 1'b0, rst_n = 1'b0, go = 1'b0, line = 1'b0;
  logic [7:0] node_id = 8'h3C;
  logic wr_en, done, bcast;
  logic [3:0] wr_addr;
  logic [7:0] wr_data;
  logic [1:0] err_code;
  logic [4:0] data_cnt;

  pw_frame_rx #(.THRESH(THRESH), .TIMEOUT(TIMEOUT), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .go(go), .line(line), .node_id(node_id),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .done(done),
    .err_code(err_code), .data_cnt(data_cnt), .bcast(bcast));

  always #4 clk = ~clk;

  int checks = 0, failures = 0;
  int wr_count, done_count, d_err, d_cnt, d_bc;
  int h0 = 6, h1 = 13, lo = 6;
  logic [7:0] wbuf [0:31];
  logic [7:0] pay [0:31];
  logic [15:0] mcrc;

  always @(negedge clk) begin
    if (wr_en) begin
      wbuf[wr_addr] = wr_data;
      wr_count++;
    end
    if (done) begin
      done_count++;
      d_err = int'(err_code);
      d_cnt = int'(data_cnt);
      d_bc = int'(bcast);
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_step(logic [15:0] c, logic b);
    crc_step = {1'b0, c[15:1]} ^ ((c[0] ^ b) ? 16'hA001 : 16'h0000);
  endfunction

  task automatic send_bit(input logic b, input int hi, input int low);
    line = 1'b1;
    repeat (hi) @(negedge clk);
    line = 1'b0;
    repeat (low) @(negedge clk);
    mcrc = crc_step(mcrc, b);
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) send_bit(v[i], v[i] ? h1 : h0, lo);
  endtask

  task automatic start_frame();
    mcrc = 16'h0;
    @(negedge clk);
    line = 1'b1;
    go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    repeat (20) @(negedge clk);
    line = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic send_crc(input logic bad);
    logic [15:0] c;
    c = mcrc;
    for (int i = 0; i < 16; i++) begin
      logic b;
      b = c[i] ^ (bad && i == 0);
      send_bit(b, b ? h1 : h0, lo);
    end
  endtask

  task automatic clr_mon();
    wr_count = 0;
    done_count = 0;
    d_err = -1;
    d_cnt = -1;
    d_bc = -1;
  endtask

  task automatic fill(input int seed);
    for (int i = 0; i < 32; i++) pay[i] = 8'(i * 37 + seed);
  endtask

  task automatic run_frame(input logic [1:0] dir, input int len, input logic [7:0] addr, input logic bad);
    clr_mon();
    start_frame();
    send_byte({dir, 1'b0, 5'(len)});
    send_byte(addr);
    for (int i = 0; i <= len; i++) send_byte(pay[i]);
    send_crc(bad);
    repeat (8) @(negedge clk);
  endtask

  function automatic int data_ok(input int len);
    data_ok = 1;
    for (int i = 0; i <= len; i++) if (wbuf[i] !== pay[i]) data_ok = 0;
  endfunction

  task automatic t_reset();
    check("R1 done", int'(done), 0);
    check("R1 wr_en", int'(wr_en), 0);
    check("R1 err_code", int'(err_code), 0);
    check("R1 data_cnt", int'(data_cnt), 0);
    check("R1 bcast", int'(bcast), 0);
  endtask

  task automatic t_unicast();
    fill(5);
    run_frame(2'b10, 3, 8'h3C, 1'b0);
    check("R10 done pulses", done_count, 1);
    check("R9 err ok", d_err, 0);
    check("R9 data_cnt", d_cnt, 3);
    check("R5 bcast unicast", d_bc, 0);
    check("R8 write count", wr_count, 4);
    check("R8 data", data_ok(3), 1);
  endtask

  task automatic t_broadcast();
    fill(91);
    run_frame(2'b10, 0, 8'hFF, 1'b0);
    check("R5 bcast", d_bc, 1);
    check("R5 err", d_err, 0);
    check("R8 writes", wr_count, 1);
    check("R8 data", data_ok(0), 1);
  endtask

  task automatic t_wrong_addr();
    fill(17);
    run_frame(2'b10, 2, 8'h3D, 1'b0);
    check("R6 done", done_count, 1);
    check("R6 err", d_err, 1);
    check("R6 bcast", d_bc, 0);
    check("R6 no writes", wr_count, 0);
  endtask

  task automatic t_dir_ignored();
    fill(3);
    run_frame(2'b00, 2, 8'h3C, 1'b0);
    check("R4 no done", done_count, 0);
    check("R4 no writes", wr_count, 0);
  endtask

  task automatic t_length();
    fill(44);
    run_frame(2'b10, DEPTH - 1, 8'h3C, 1'b0);
    check("R7 full fits err", d_err, 0);
    check("R7 full fits writes", wr_count, DEPTH);
    check("R8 full data", data_ok(DEPTH - 1), 1);
    run_frame(2'b10, DEPTH, 8'h3C, 1'b0);
    check("R7 too long done", done_count, 1);
    check("R7 too long err", d_err, 2);
    check("R7 too long writes", wr_count, 0);
  endtask

  task automatic t_bad_crc();
    fill(200);
    run_frame(2'b01, 2, 8'h3C, 1'b1);
    check("R9 crc err", d_err, 3);
    check("R9 crc data_cnt", d_cnt, 2);
    check("R9 crc writes", wr_count, 3);
  endtask

  task automatic t_threshold();
    fill(0);
    pay[1] = 8'hA5;
    pay[2] = 8'h5A;
    h0 = THRESH - 1;
    h1 = THRESH;
    run_frame(2'b10, 2, 8'h3C, 1'b0);
    h0 = 6;
    h1 = 13;
    check("R2 threshold err", d_err, 0);
    check("R2 threshold data", data_ok(2), 1);
  endtask

  task automatic t_timeout_edge();
    fill(9);
    h1 = TIMEOUT;
    lo = TIMEOUT;
    run_frame(2'b10, 1, 8'h3C, 1'b0);
    h1 = 13;
    lo = 6;
    check("R3 edge done", done_count, 1);
    check("R3 edge err", d_err, 0);
    check("R3 edge data", data_ok(1), 1);
  endtask

  task automatic t_abort(input int hi, input int low, input string tag);
    fill(77);
    clr_mon();
    start_frame();
    send_byte(8'h82);
    send_bit(1'b1, hi, low);
    for (int i = 0; i < 7; i++) send_bit(1'b0, 6, 6);
    for (int i = 0; i < 4; i++) send_byte(pay[i]);
    repeat (8) @(negedge clk);
    check({tag, " no done"}, done_count, 0);
    check({tag, " no writes"}, wr_count, 0);
    run_frame(2'b10, 1, 8'h3C, 1'b0);
    check({tag, " recovers"}, done_count, 1);
    check({tag, " recovered err"}, d_err, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_unicast();
    t_broadcast();
    t_wrong_addr();
    t_dir_ignored();
    t_length();
    t_bad_crc();
    t_threshold();
    t_timeout_edge();
    t_abort(TIMEOUT + 1, 6, "R3 high");
    t_abort(13, TIMEOUT + 1, "R3 low");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule